// File: doc/BRIEF.md
# Octal Trim-DAC Serial Write Controller

This block sits on the host side of a serially programmed eight-channel multiplying DAC. A user asks for a channel to be written by offering a channel address and an 8-bit code under a valid/ready handshake. The controller turns each legal request into a 12-bit serial frame, with the address in the top nibble and the code below it. It shifts the frame out on a data line against a serial clock that it derives from the system clock. It then raises a load strobe while the serial clock is parked low, so that the device takes the new code.

A separate one-cycle clear request drives the active-low preset line for one half-period of the serial clock, with the load strobe held low. This returns every device code to zero. The controller keeps a shadow copy of the eight codes, and the user reads it back through a channel index. A shadow entry changes only when its frame's strobe pulse has finished, or when a preset completes. Requests that name no channel are answered with an error pulse and never reach the wire.

Top module: `trimdac_wr_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `dac_load` is 0, `dac_clr_n` is 1, `dac_sclk` is 0, `req_ready` is 1 and every shadow code reads back as 0.
- R2: A legal request produces exactly 12 rising `dac_sclk` edges before the next `dac_load` pulse. The values of `dac_sdata` taken at those edges, most significant first, form a word whose bits [11:8] are `req_chan` and whose bits [7:0] are `req_code`.
- R3: Every high phase of `dac_sclk` lasts exactly `HALF_DIV` system clocks, and `dac_sdata` does not change while `dac_sclk` is high.
- R4: `dac_load` rises only while `dac_sclk` is low. `dac_sclk` stays low for the whole strobe, and the strobe is high for exactly `HALF_DIV` system clocks.
- R5: A request whose `req_chan` is 0 or 9 to 15 is accepted and answered by `req_err` high on the following cycle. It produces no frame and leaves every shadow code unchanged.
- R6: `req_ready` is low from the cycle after a legal request is accepted until at least one half-period after `dac_load` has fallen, and it is low whenever `dac_load` is high.
- R7: `rd_code` shows, without alteration, the last code written to the channel whose address is `rd_sel`+1. Channels that have not been written since reset or preset read as 0.
- R8: A clear request drives `dac_clr_n` low for exactly `HALF_DIV` system clocks, with `dac_load` and `dac_sclk` low throughout. After that every shadow code reads 0.
- R9: A clear request that arrives while a frame is in flight is performed after that frame. No write request is accepted until the preset has finished, so a write offered behind the clear is applied after the preset.
- R10: `dac_clr_n` is high at every rising edge of `dac_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_chan | input | ADDR_W (4) | Channel address, legal range 1 to 8 |
| req_code | input | CODE_W (8) | Code for the channel |
| req_err | output | 1 | One-cycle pulse: an illegal address was refused |
| clr_req | input | 1 | One-cycle request to preset all channels to zero |
| rd_sel | input | 3 | Shadow readback index (channel address minus 1) |
| rd_code | output | CODE_W (8) | Shadow code of the selected channel |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_sdata | output | 1 | Serial data to the DAC |
| dac_load | output | 1 | Load strobe, active high |
| dac_clr_n | output | 1 | Preset line, active low |

## Verification
A wrong bit counter or shift register shows up at the very next strobe. The word collected on the rising serial-clock edges then differs from the queued request, or it holds a number of bits other than 12. A divider or sequencer that goes astray shows up as a serial-clock high phase, strobe width or preset width that is not `HALF_DIV` cycles long, and the bench catches it on the falling edge concerned. Errors in the shadow bank or the commit index appear on the readback port once the frame that should have written the entry has finished. The ordering test catches a preset that is lost or reordered, because the channel written just before the clear must then read zero.

// File: rtl/trimdac_pkg.sv
`timescale 1ns/1ps
package trimdac_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_LSETUP,
      ST_LHIGH,
      ST_GAP,
      ST_PRESET
   } seq_state_e;
endpackage

// File: rtl/trimdac_halfdiv.sv
`timescale 1ns/1ps
// Half-period tick generator: pulses tick once every HALF_DIV cycles while run is high.
module trimdac_halfdiv #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam bit POW2 = ((1 << CW) == HALF_DIV);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two divide: the counter wraps by itself
         always_ff @(posedge clk) begin
            if (rst || !run) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
         assign tick = run && (&cnt);
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst || !run)                      cnt <= '0;
            else if (cnt == CW'(HALF_DIV - 1))    cnt <= '0;
            else                                  cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/trimdac_seq.sv
`timescale 1ns/1ps
// Frame sequencer: handshake, shifting, strobe and preset ordering.
module trimdac_seq import trimdac_pkg::*; #(
   parameter int ADDR_W     = 4,
   parameter int CODE_W     = 8,
   parameter int N_CHAN     = 8,
   parameter int FIRST_ADDR = 1,
   parameter int IDX_W      = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_chan,
   input  logic [CODE_W-1:0] req_code,
   input  logic              clr_req,
   input  logic              tick,
   output logic              run,
   output logic              req_ready,
   output logic              req_err,
   output logic              sclk,
   output logic              sdata,
   output logic              load,
   output logic              clr_n,
   output logic              commit,
   output logic [IDX_W-1:0]  commit_idx,
   output logic [CODE_W-1:0] commit_code,
   output logic              wipe
);
   localparam int FRAME_W = ADDR_W + CODE_W;
   localparam int BIT_CW  = $clog2(FRAME_W);
   localparam int LAST_A  = FIRST_ADDR + N_CHAN;

   seq_state_e          state;
   logic [FRAME_W-1:0]  sreg;
   logic [BIT_CW-1:0]   bitcnt;
   logic                clr_pend;
   logic                legal;

   assign legal = ({1'b0, req_chan} >= (ADDR_W+1)'(FIRST_ADDR)) &&
                  ({1'b0, req_chan} <  (ADDR_W+1)'(LAST_A));

   assign run       = (state != ST_IDLE);
   assign req_ready = (state == ST_IDLE) && !clr_pend;
   assign sdata     = sreg[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         sreg        <= '0;
         bitcnt      <= '0;
         sclk        <= 1'b0;
         load        <= 1'b0;
         clr_n       <= 1'b1;
         clr_pend    <= 1'b0;
         req_err     <= 1'b0;
         commit      <= 1'b0;
         wipe        <= 1'b0;
         commit_idx  <= '0;
         commit_code <= '0;
      end else begin
         req_err <= 1'b0;
         commit  <= 1'b0;
         wipe    <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (clr_pend) begin
                  clr_pend <= 1'b0;
                  clr_n    <= 1'b0;
                  state    <= ST_PRESET;
               end else if (req_valid) begin
                  if (legal) begin
                     sreg        <= {req_chan, req_code};
                     commit_idx  <= IDX_W'(req_chan - ADDR_W'(FIRST_ADDR));
                     commit_code <= req_code;
                     bitcnt      <= '0;
                     state       <= ST_SHIFT;
                  end else begin
                     req_err <= 1'b1;
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (bitcnt == BIT_CW'(FRAME_W - 1)) begin
                        state <= ST_LSETUP;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                        sreg   <= {sreg[FRAME_W-2:0], 1'b0};
                     end
                  end
               end
            end
            ST_LSETUP: begin
               if (tick) begin
                  load  <= 1'b1;
                  state <= ST_LHIGH;
               end
            end
            ST_LHIGH: begin
               if (tick) begin
                  load   <= 1'b0;
                  commit <= 1'b1;
                  state  <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) state <= ST_IDLE;
            end
            ST_PRESET: begin
               if (tick) begin
                  clr_n <= 1'b1;
                  wipe  <= 1'b1;
                  state <= ST_GAP;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (clr_req) clr_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/trimdac_shadow.sv
`timescale 1ns/1ps
// Shadow copy of the channel codes with indexed readback.
module trimdac_shadow #(
   parameter int N_CHAN = 8,
   parameter int CODE_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              wipe,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CODE_W-1:0] rd_code
);
   logic [CODE_W-1:0] bank [N_CHAN];

   generate
      for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
         always_ff @(posedge clk) begin
            if (rst || wipe)
               bank[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               bank[g] <= wr_code;
         end
      end
   endgenerate

   always_comb begin
      rd_code = '0;
      for (int i = 0; i < N_CHAN; i++)
         if (rd_idx == IDX_W'(i)) rd_code = bank[i];
   end
endmodule

// File: rtl/trimdac_wr_ctrl.sv
`timescale 1ns/1ps
module trimdac_wr_ctrl #(
   parameter int ADDR_W     = 4,
   parameter int CODE_W     = 8,
   parameter int N_CHAN     = 8,
   parameter int FIRST_ADDR = 1,
   parameter int HALF_DIV   = 4,
   parameter int IDX_W      = $clog2(N_CHAN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_chan,
   input  logic [CODE_W-1:0] req_code,
   output logic              req_err,
   input  logic              clr_req,
   input  logic [IDX_W-1:0]  rd_sel,
   output logic [CODE_W-1:0] rd_code,
   output logic              dac_sclk,
   output logic              dac_sdata,
   output logic              dac_load,
   output logic              dac_clr_n
);
   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("HALF_DIV must be at least 2");
      end
      if (FIRST_ADDR < 1 || FIRST_ADDR + N_CHAN > (1 << ADDR_W)) begin : g_bad_map
         $error("channel range does not fit the address field");
      end
      if ((1 << IDX_W) < N_CHAN) begin : g_bad_idx
         $error("IDX_W too narrow for N_CHAN");
      end
   endgenerate

   logic              run, tick, commit, wipe;
   logic [IDX_W-1:0]  commit_idx;
   logic [CODE_W-1:0] commit_code;

   trimdac_halfdiv #(.HALF_DIV(HALF_DIV)) div_i (
      .clk (clk),
      .rst (rst),
      .run (run),
      .tick(tick)
   );

   trimdac_seq #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .N_CHAN(N_CHAN),
      .FIRST_ADDR(FIRST_ADDR), .IDX_W(IDX_W)
   ) seq_i (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_chan   (req_chan),
      .req_code   (req_code),
      .clr_req    (clr_req),
      .tick       (tick),
      .run        (run),
      .req_ready  (req_ready),
      .req_err    (req_err),
      .sclk       (dac_sclk),
      .sdata      (dac_sdata),
      .load       (dac_load),
      .clr_n      (dac_clr_n),
      .commit     (commit),
      .commit_idx (commit_idx),
      .commit_code(commit_code),
      .wipe       (wipe)
   );

   trimdac_shadow #(.N_CHAN(N_CHAN), .CODE_W(CODE_W), .IDX_W(IDX_W)) shadow_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (commit),
      .wr_idx (commit_idx),
      .wr_code(commit_code),
      .wipe   (wipe),
      .rd_idx (rd_sel),
      .rd_code(rd_code)
   );
endmodule

// File: rtl/trimdac_wr_ctrl_chk.sv
`timescale 1ns/1ps
module trimdac_wr_ctrl_chk #(
   parameter int ADDR_W     = 4,
   parameter int N_CHAN     = 8,
   parameter int FIRST_ADDR = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_chan,
   input logic              req_err,
   input logic              dac_sclk,
   input logic              dac_sdata,
   input logic              dac_load,
   input logic              dac_clr_n
);
   logic bad_addr;
   assign bad_addr = (int'(req_chan) < FIRST_ADDR) || (int'(req_chan) >= FIRST_ADDR + N_CHAN);

   p_load_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
      dac_load |-> !dac_sclk);

   p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
      (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdata));

   p_busy_in_load_r6: assert property (@(posedge clk) disable iff (rst)
      dac_load |-> !req_ready);

   p_err_cause_r5: assert property (@(posedge clk) disable iff (rst)
      req_err |-> $past(req_valid && req_ready && bad_addr));

   p_preset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !dac_clr_n |-> (!dac_load && !dac_sclk));

   p_no_preset_shift_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(dac_sclk) |-> dac_clr_n);
endmodule

bind trimdac_wr_ctrl trimdac_wr_ctrl_chk #(
   .ADDR_W(ADDR_W), .N_CHAN(N_CHAN), .FIRST_ADDR(FIRST_ADDR)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_chan (req_chan),
   .req_err  (req_err),
   .dac_sclk (dac_sclk),
   .dac_sdata(dac_sdata),
   .dac_load (dac_load),
   .dac_clr_n(dac_clr_n)
);

// File: tb/trimdac_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module trimdac_wr_ctrl_tb_top;
   localparam int HD = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [3:0] req_chan = '0;
   logic [7:0] req_code = '0;
   logic       req_err;
   logic       clr_req = 1'b0;
   logic [2:0] rd_sel = '0;
   logic [7:0] rd_code;
   logic       dac_sclk, dac_sdata, dac_load, dac_clr_n;

   always #2.5 clk = ~clk;

   trimdac_wr_ctrl #(.HALF_DIV(HD)) dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_chan(req_chan), .req_code(req_code), .req_err(req_err),
      .clr_req(clr_req), .rd_sel(rd_sel), .rd_code(rd_code),
      .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_load(dac_load),
      .dac_clr_n(dac_clr_n)
   );

   int nchk = 0;
   int nfail = 0;
   logic [11:0] exp_q [$];
   logic [7:0]  sh [8];
   int frames = 0;
   int presets = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   // Monitor: rebuilds frames from the wire and compares them against the queue
   logic        p_sclk = 1'b0, p_sdata = 1'b0, p_load = 1'b0, p_clr_n = 1'b1;
   logic [11:0] word = '0;
   int          nbits = 0, hi_len = 0, ld_len = 0, cl_len = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (dac_sclk && !p_sclk) begin
            chk(dac_clr_n == 1'b1, "R10 clr_n at sclk rise", dac_clr_n, 1);
            word = {word[10:0], dac_sdata};
            nbits++;
            hi_len = 1;
         end else if (dac_sclk) begin
            hi_len++;
            chk(dac_sdata == p_sdata, "R3 data stable in high phase", dac_sdata, p_sdata);
         end
         if (!dac_sclk && p_sclk)
            chk(hi_len == HD, "R3 sclk high width", hi_len, HD);

         if (dac_load && !p_load) begin
            chk(!dac_sclk, "R4 strobe with sclk low", dac_sclk, 0);
            chk(nbits == 12, "R2 bit count", nbits, 12);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected frame", word, 0);
            end else begin
               logic [11:0] e;
               e = exp_q.pop_front();
               chk(word == e, "R2 frame content", word, e);
            end
            nbits = 0;
            frames++;
            ld_len = 1;
         end else if (dac_load) begin
            ld_len++;
            chk(!dac_sclk, "R4 sclk low during strobe", dac_sclk, 0);
         end
         if (!dac_load && p_load)
            chk(ld_len == HD, "R4 strobe width", ld_len, HD);

         if (!dac_clr_n && p_clr_n) begin
            cl_len = 1;
            chk(!dac_load && !dac_sclk, "R8 preset lines quiet", {dac_load, dac_sclk}, 0);
         end else if (!dac_clr_n) begin
            cl_len++;
         end
         if (dac_clr_n && !p_clr_n) begin
            chk(cl_len == HD, "R8 preset width", cl_len, HD);
            presets++;
         end
         p_sclk  = dac_sclk;
         p_sdata = dac_sdata;
         p_load  = dac_load;
         p_clr_n = dac_clr_n;
      end
   end

   // Driver tasks
   task automatic wr(input logic [3:0] ch, input logic [7:0] cd);
      bit legal;
      legal = (ch >= 1) && (ch <= 8);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_chan  = ch;
      req_code  = cd;
      if (legal) begin
         exp_q.push_back({ch, cd});
         sh[ch-1] = cd;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (legal) begin
         chk(req_ready == 1'b0, "R6 ready low after accept", req_ready, 0);
         chk(req_err == 1'b0, "R5 no error on legal address", req_err, 0);
      end else begin
         chk(req_err == 1'b1, "R5 error on illegal address", req_err, 1);
      end
   endtask

   task automatic preset_pulse();
      @(negedge clk);
      clr_req = 1'b1;
      for (int i = 0; i < 8; i++) sh[i] = '0;
      @(negedge clk);
      clr_req = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
      repeat (3 * HD) @(negedge clk);
      chk(req_ready == 1'b1, "R6 ready back when idle", req_ready, 1);
   endtask

   task automatic check_shadow(input string tag);
      for (int i = 0; i < 8; i++) begin
         rd_sel = 3'(i);
         #1;
         chk(rd_code == sh[i], tag, rd_code, sh[i]);
      end
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int f0;
      for (int i = 0; i < 8; i++) sh[i] = '0;
      repeat (4) @(negedge clk);
      // R1: reset values
      chk(dac_load == 0 && dac_clr_n == 1 && dac_sclk == 0, "R1 line levels in reset",
          {dac_load, dac_clr_n, dac_sclk}, 3'b010);
      chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(dac_load == 0 && dac_clr_n == 1 && dac_sclk == 0, "R1 line levels after reset",
          {dac_load, dac_clr_n, dac_sclk}, 3'b010);
      check_shadow("R1 shadow zero after reset");

      // R2 / R7: frames for several patterns, including gain end points
      wr(4'd1, 8'h80);
      wr(4'd8, 8'hFF);
      wr(4'd3, 8'h00);
      wr(4'd5, 8'h5A);
      wait_idle();
      chk(frames == 4, "R2 frame count", frames, 4);
      check_shadow("R7 shadow readback");

      // R5: illegal addresses
      f0 = frames;
      wr(4'd0, 8'h11);
      wr(4'd9, 8'h22);
      wr(4'd15, 8'h33);
      wait_idle();
      chk(frames == f0, "R5 no frame for illegal address", frames, f0);
      check_shadow("R5 shadow unchanged");

      // R8: preset clears everything
      preset_pulse();
      wait_idle();
      chk(presets == 1, "R8 preset issued", presets, 1);
      check_shadow("R8 shadow zero after preset");

      // R9: clear during a frame runs after it, later write waits for it
      wr(4'd2, 8'h33);
      repeat (10) @(negedge clk);
      preset_pulse();
      wr(4'd4, 8'h44);
      wait_idle();
      chk(presets == 2, "R9 deferred preset issued", presets, 2);
      chk(frames == f0 + 2, "R9 both frames sent", frames, f0 + 2);
      check_shadow("R9 ordering of preset and writes");

      // R7: overwrite one channel, others untouched
      wr(4'd4, 8'h7F);
      wr(4'd6, 8'h81);
      wait_idle();
      check_shadow("R7 overwrite readback");

      summary();
      $finish;
   end
endmodule